// File: doc/BRIEF.md
# Orbit Pulse Conditioning Channel

This block handles one orbit timing channel inside the bunch-clock domain, where one tick lasts 25 ns at 40.078 MHz. An orbit marker arrives asynchronously. It is brought into the clock domain and reduced to a single one-tick event. Instead of the external marker, the block can also use a free-running internal orbit generator whose period is set in ticks. The chosen event is then shifted by a coarse delay counted in whole ticks. It is widened to a programmed pulse width with a fixed floor of three ticks, and it can leave the block active-low.

All pins are plain level signals. The orbit output is a timing waveform and not a data stream, so no valid/ready handshake is used and no back-pressure exists. Configuration inputs are expected to be stable while pulses are in flight. The internal generator counter is brought out so that it can be read for debugging. Its clear input is a write-one pulse that takes priority over counting.

Top module: `orbit_chan`

## Requirements
- R1: While reset is asserted and afterwards until the first event, `orb_o` equals `invert_i` (inactive) and `gen_count_o` is 0.
- R2: With the external source selected (`src_internal_i`=0), count the first rising clock edge that samples `orb_async_i` high as edge 1. `orb_o` then becomes active right after edge 4+D, where D is the effective coarse delay.
- R3: One rising transition of `orb_async_i` produces exactly one output pulse, however long the input stays high.
- R4: An output pulse lasts max(3, `length_i`+1) ticks. `length_i` is 8 bits wide, so the widest pulse is 256 ticks.
- R5: A `delay_i` value above 3563 acts exactly like 3563.
- R6: An event that arrives while an earlier delay is still counting discards the earlier one and restarts the delay. Only the later event produces a pulse.
- R7: The generator counter steps by one per tick while `gen_enable_i` is 1 and holds while it is 0. After reaching period−1 it wraps to 0. A `gen_period_i` of 0 selects a period of 3564. A high `gen_clear_i` forces the count to 0 on the next edge, whatever the enable. `gen_count_o` shows the count.
- R8: With the internal source selected, count as edge 1 an edge at which the enabled counter holds 0. `orb_o` becomes active right after edge D+2, so pulses repeat once per period.
- R9: The source that is not selected has no effect. The external input is ignored in internal mode, and generator events are ignored in external mode.
- R10: When `invert_i` is 1, `orb_o` is low while the pulse is active and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| orb_async_i | input | 1 | Asynchronous external orbit marker |
| src_internal_i | input | 1 | 0 selects the external marker, 1 selects the internal generator |
| gen_enable_i | input | 1 | Internal generator counter runs when 1 |
| gen_clear_i | input | 1 | Write-one pulse that zeroes the generator counter |
| gen_period_i | input | 12 | Generator period in ticks; 0 selects 3564 |
| delay_i | input | 12 | Coarse delay in ticks; clamped to 3563 |
| length_i | input | 8 | Pulse width setting; width is max(3, value+1) ticks |
| invert_i | input | 1 | 1 makes the output active-low |
| gen_count_o | output | 12 | Current generator counter value |
| orb_o | output | 1 | Conditioned orbit output |

## Verification
The bench targets the following corner cases:

- **Input held high for many ticks.** A synchronizer that reacts to level instead of to the rising edge would emit a train of pulses here.
- **Length values 0 and 255.** A stretcher that used `length_i`+1 directly would give a pulse one or two ticks wide for a length of 0. A counter one bit too narrow would truncate the 256-tick pulse.
- **Delay of 4095.** Without the clamp, this would push the pulse past one orbit.
- **Second marker inside a pending delay.** A design that queued events, or that ignored the later one, would show up as a pulse at the wrong time or as one pulse too many.
- **Internal mode.** Each pulse is timed against the generator period. The counter is read back while it runs, while it holds and after a clear. The unselected source is exercised in both directions, and any pulse that nobody expected is reported.

// File: rtl/orbit_chan_pkg.sv
package orbit_chan_pkg;
  // Longest legal coarse shift, one tick short of a full orbit
  localparam int ORB_MAX_DELAY  = 3563;
  // Generator period used when the period input is zero
  localparam int ORB_DEF_PERIOD = 3564;
  // Floor on the output pulse width in ticks
  localparam int ORB_MIN_WIDTH  = 3;
  localparam int ORB_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } orb_src_e;
endpackage

// File: rtl/orbit_sync_edge.sv
module orbit_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic evt_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_i};
  end

  assign evt_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/orbit_int_gen.sv
module orbit_int_gen #(
  parameter int PER_W      = 12,
  parameter int DEF_PERIOD = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] count_o,
  output logic             evt_o
);
  logic [PER_W-1:0] per_eff;
  logic [PER_W-1:0] last;
  logic [PER_W-1:0] cnt;

  assign per_eff = (period_i == '0) ? PER_W'(DEF_PERIOD) : period_i;
  assign last    = per_eff - PER_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear_i)  cnt <= '0;
    else if (enable_i) cnt <= (cnt >= last) ? '0 : cnt + PER_W'(1);
  end

  assign count_o = cnt;
  assign evt_o   = enable_i & ~clear_i & (cnt == '0);
endmodule

// File: rtl/orbit_coarse_delay.sv
module orbit_coarse_delay #(
  parameter int DLY_W     = 12,
  parameter int MAX_DELAY = 3563
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             fire_o,
  output logic             pending_o,
  output logic [DLY_W-1:0] cnt_o
);
  logic [DLY_W-1:0] d_eff;
  logic [DLY_W-1:0] cnt;
  logic             pending;
  logic             fire;

  assign d_eff = (delay_i > DLY_W'(MAX_DELAY)) ? DLY_W'(MAX_DELAY) : delay_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (evt_i) begin
        // a fresh event always wins over one still counting
        if (d_eff == '0) begin
          fire    <= 1'b1;
          pending <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt     <= d_eff;
          pending <= 1'b1;
        end
      end else if (pending) begin
        if (cnt == DLY_W'(1)) begin
          fire    <= 1'b1;
          pending <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt - DLY_W'(1);
        end
      end
    end
  end

  assign fire_o    = fire;
  assign pending_o = pending;
  assign cnt_o     = cnt;
endmodule

// File: rtl/orbit_stretch.sv
module orbit_stretch #(
  parameter int LEN_W     = 8,
  parameter int MIN_WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [LEN_W-1:0] length_i,
  output logic             active_o
);
  localparam int CW = LEN_W + 1;

  logic [CW-1:0] len_p1;
  logic [CW-1:0] w_eff;
  logic [CW-1:0] rem;

  assign len_p1 = {1'b0, length_i} + CW'(1);
  assign w_eff  = (len_p1 < CW'(MIN_WIDTH)) ? CW'(MIN_WIDTH) : len_p1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rem <= '0;
    else if (fire_i)     rem <= w_eff;
    else if (rem != '0)  rem <= rem - CW'(1);
  end

  assign active_o = (rem != '0);
endmodule

// File: rtl/orbit_chan.sv
module orbit_chan
  import orbit_chan_pkg::*;
#(
  parameter int DLY_W       = 12,
  parameter int PER_W       = 12,
  parameter int LEN_W       = 8,
  parameter int MAX_DELAY   = ORB_MAX_DELAY,
  parameter int DEF_PERIOD  = ORB_DEF_PERIOD,
  parameter int MIN_WIDTH   = ORB_MIN_WIDTH,
  parameter int SYNC_STAGES = ORB_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orb_async_i,
  input  logic             src_internal_i,
  input  logic             gen_enable_i,
  input  logic             gen_clear_i,
  input  logic [PER_W-1:0] gen_period_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [LEN_W-1:0] length_i,
  input  logic             invert_i,
  output logic [PER_W-1:0] gen_count_o,
  output logic             orb_o
);
  logic             ext_evt;
  logic             int_evt;
  logic             sel_evt;
  logic             fire;
  logic             pending;
  logic [DLY_W-1:0] dly_cnt;
  logic             active;
  orb_src_e         src;

  orbit_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (orb_async_i),
    .evt_o   (ext_evt)
  );

  orbit_int_gen #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (gen_enable_i),
    .clear_i  (gen_clear_i),
    .period_i (gen_period_i),
    .count_o  (gen_count_o),
    .evt_o    (int_evt)
  );

  assign src     = orb_src_e'(src_internal_i);
  assign sel_evt = (src == SRC_INT) ? int_evt : ext_evt;

  orbit_coarse_delay #(.DLY_W(DLY_W), .MAX_DELAY(MAX_DELAY)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (sel_evt),
    .delay_i   (delay_i),
    .fire_o    (fire),
    .pending_o (pending),
    .cnt_o     (dly_cnt)
  );

  orbit_stretch #(.LEN_W(LEN_W), .MIN_WIDTH(MIN_WIDTH)) u_str (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire),
    .length_i (length_i),
    .active_o (active)
  );

  assign orb_o = active ^ invert_i;
endmodule

// File: rtl/orbit_chan_chk.sv
module orbit_chan_chk #(
  parameter int DLY_W      = 12,
  parameter int PER_W      = 12,
  parameter int MAX_DELAY  = 3563,
  parameter int DEF_PERIOD = 3564
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_enable_i,
  input logic             gen_clear_i,
  input logic [PER_W-1:0] gen_period_i,
  input logic [PER_W-1:0] gen_count_o,
  input logic             ext_evt,
  input logic             fire,
  input logic             pending,
  input logic [DLY_W-1:0] dly_cnt,
  input logic             active
);
  logic [PER_W:0] chk_period;
  assign chk_period = (gen_period_i == '0) ? (PER_W+1)'(DEF_PERIOD) : {1'b0, gen_period_i};

  assert_reset_count_R1: assert property (@(posedge clk)
    !rst_n |=> (gen_count_o == '0));

  assert_fire_to_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);

  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> !ext_evt);

  assert_min_width_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> active);

  assert_min_width_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ##2 active);

  assert_delay_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ({1'b0, dly_cnt} <= (DLY_W+1)'(MAX_DELAY)));

  assert_count_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_enable_i && !gen_clear_i && ({1'b0, gen_count_o} == chk_period - 1'b1))
      |=> (gen_count_o == '0));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_enable_i && !gen_clear_i) |=> $stable(gen_count_o));

  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clear_i |=> (gen_count_o == '0));
endmodule

bind orbit_chan orbit_chan_chk #(
  .DLY_W(DLY_W), .PER_W(PER_W), .MAX_DELAY(MAX_DELAY), .DEF_PERIOD(DEF_PERIOD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gen_enable_i (gen_enable_i),
  .gen_clear_i  (gen_clear_i),
  .gen_period_i (gen_period_i),
  .gen_count_o  (gen_count_o),
  .ext_evt      (ext_evt),
  .fire         (fire),
  .pending      (pending),
  .dly_cnt      (dly_cnt),
  .active       (active)
);

// File: tb/orbit_chan_test.sv
`timescale 1ns/1ps
module orbit_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        orb_async_i = 1'b0;
  logic        src_internal_i = 1'b0;
  logic        gen_enable_i = 1'b0;
  logic        gen_clear_i = 1'b0;
  logic [11:0] gen_period_i = 12'd0;
  logic [11:0] delay_i = 12'd0;
  logic [7:0]  length_i = 8'd0;
  logic        invert_i = 1'b0;
  logic [11:0] gen_count_o;
  logic        orb_o;

  orbit_chan uut (
    .clk(clk), .rst_n(rst_n), .orb_async_i(orb_async_i),
    .src_internal_i(src_internal_i), .gen_enable_i(gen_enable_i),
    .gen_clear_i(gen_clear_i), .gen_period_i(gen_period_i),
    .delay_i(delay_i), .length_i(length_i), .invert_i(invert_i),
    .gen_count_o(gen_count_o), .orb_o(orb_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  typedef struct {
    int    start;
    int    width;
    string tag;
  } exp_t;
  exp_t exq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  function automatic int eff_delay();
    return (delay_i > 12'd3563) ? 3563 : int'(delay_i);
  endfunction

  function automatic int eff_width();
    return (int'(length_i) + 1 < 3) ? 3 : int'(length_i) + 1;
  endfunction

  // raise the external marker for hi ticks; optionally record the expected pulse
  task automatic ext_pulse(input int hi, input bit expect_out, input string tag);
    exp_t e;
    if (expect_out) begin
      e.start = cyc + 4 + eff_delay();
      e.width = eff_width();
      e.tag   = tag;
      exq.push_back(e);
    end
    orb_async_i = 1'b1;
    tick(hi);
    orb_async_i = 1'b0;
  endtask

  task automatic push_exp(input int start, input string tag);
    exp_t e;
    e.start = start;
    e.width = eff_width();
    e.tag   = tag;
    exq.push_back(e);
  endtask

  task automatic clear_gen();
    gen_clear_i = 1'b1;
    tick(1);
    gen_clear_i = 1'b0;
  endtask

  // monitor: measure each pulse and compare with the scoreboard
  bit mon_prev = 1'b0;
  int mon_start = 0;
  int mon_width = 0;
  always @(negedge clk) begin
    bit act;
    exp_t e;
    if (rst_n && !finished) begin
      act = orb_o ^ invert_i;
      if (act && !mon_prev) begin
        mon_start = cyc;
        mon_width = 0;
      end
      if (act) mon_width++;
      if (!act && mon_prev) begin
        if (exq.size() == 0) begin
          check(1'b0, "R9", "unexpected pulse start", mon_start, -1);
        end else begin
          e = exq.pop_front();
          check(mon_start == e.start, e.tag, "pulse start", mon_start, e.start);
          check(mon_width == e.width, e.tag, "pulse width", mon_width, e.width);
        end
      end
      mon_prev = act;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    tick(3);
    check(orb_o == 1'b0, "R1", "orb_o in reset", int'(orb_o), 0);
    check(gen_count_o == 12'd0, "R1", "count in reset", int'(gen_count_o), 0);
    rst_n = 1'b1;
    tick(5);
    check(orb_o == 1'b0, "R1", "orb_o after reset", int'(orb_o), 0);

    // R2 R4: minimum latency, minimum width
    delay_i = 0; length_i = 0;
    ext_pulse(1, 1'b1, "R2");
    tick(20);
    delay_i = 5; length_i = 10;
    ext_pulse(1, 1'b1, "R2");
    tick(30);
    // R3: long input gives a single pulse
    delay_i = 2; length_i = 2;
    ext_pulse(30, 1'b1, "R3");
    tick(20);
    // R4: length values 1 and 255
    delay_i = 0; length_i = 1;
    ext_pulse(2, 1'b1, "R4");
    tick(20);
    length_i = 8'd255;
    ext_pulse(2, 1'b1, "R4");
    tick(280);
    // R5: delay clamp
    delay_i = 12'd4095; length_i = 0;
    ext_pulse(1, 1'b1, "R5");
    tick(3600);
    // R6: restart within a pending delay
    delay_i = 20; length_i = 4;
    ext_pulse(2, 1'b0, "R6");
    tick(8);
    ext_pulse(2, 1'b1, "R6");
    tick(50);
    // R10: inverted output
    invert_i = 1'b1;
    tick(2);
    check(orb_o == 1'b1, "R10", "idle level inverted", int'(orb_o), 1);
    delay_i = 3; length_i = 4;
    ext_pulse(1, 1'b1, "R10");
    tick(20);
    invert_i = 1'b0;
    tick(2);

    // R7 R8 R9: internal generator, external marker ignored
    src_internal_i = 1'b1;
    gen_period_i = 12'd50; delay_i = 3; length_i = 0;
    clear_gen();
    check(gen_count_o == 12'd0, "R7", "count after clear", int'(gen_count_o), 0);
    n = cyc;
    gen_enable_i = 1'b1;
    push_exp(n + 5, "R8");
    push_exp(n + 55, "R8");
    push_exp(n + 105, "R8");
    tick(7);
    check(gen_count_o == 12'd7, "R7", "count running", int'(gen_count_o), 7);
    tick(13);
    ext_pulse(3, 1'b0, "R9");
    tick(n + 130 - cyc);
    gen_enable_i = 1'b0;
    check(gen_count_o == 12'd30, "R7", "count after wrap", int'(gen_count_o), 30);
    tick(10);
    check(gen_count_o == 12'd30, "R7", "count held", int'(gen_count_o), 30);

    // R7 R8: period 0 selects 3564
    gen_period_i = 12'd0; delay_i = 0;
    clear_gen();
    n = cyc;
    gen_enable_i = 1'b1;
    push_exp(n + 2, "R7");
    push_exp(n + 2 + 3564, "R7");
    tick(3580);
    gen_enable_i = 1'b0;
    clear_gen();

    // R9: generator runs but external source is selected
    src_internal_i = 1'b0;
    gen_period_i = 12'd50;
    gen_enable_i = 1'b1;
    tick(200);
    gen_enable_i = 1'b0;
    tick(10);

    check(exq.size() == 0, "R9", "pending expected pulses", exq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule